// File: doc/BRIEF.md
# Bit-Serial Bus Sequence Decoder

This block sits behind a processor bus and turns a stream of completed bus cycles, all carried on a single data line, into serial memory commands. Each bus cycle arrives as a one-clock pulse. A read pulse stands for one bus read. A write pulse stands for one bus write and carries one data bit. The order of these cycles is the whole command language. A read, a write of 0 and another read restart the decoder. Sixteen writes then give it an address. After that, every read returns one bit of the byte the array holds at that address.

The decoder keeps the current array address and raises a request while the array must present the byte at that address. It picks the bit that answers the next bus read and reports whether it is idle. When a byte has been fully read, the address steps on and wraps at the top of the implemented array, so sequential reads never run out. Orderings that make no sense send the decoder back to idle, and only a fresh restart pattern brings it back. Storage, page buffering and write protection live elsewhere.

Top module: `bsq_decoder`

## Requirements
- R1: After reset is released, `idle` is 1, `arr_req` is 0 and `dout` is 1.
- R2: A read pulse, then a write pulse with `wr_bit`=0, then a read pulse restarts the decoder from any state, including mid-byte during a sequential read. On the clock after the final read, `idle`=0 and `arr_req`=0.
- R3: After a restart, 16 write pulses with no read between them load a 16-bit address, most significant bit first. On the clock after the 16th write, `arr_req`=1 and `addr_o` equals the low `ARR_AW` bits of that address.
- R4: While `arr_req`=1, `dout` shows the bit the next read returns. The k-th read of a byte (k=0..BYTE_W-1) returns bit `BYTE_W-1-k` of `arr_byte`.
- R5: `addr_o` rises by one on the clock after the last read of a byte and changes at no other time while `arr_req`=1. From 2^ARR_AW-1 it wraps to 0.
- R6: A write with `wr_bit`=1 after a completed byte ends the access, and `idle`=1 on the next clock.
- R7: Whenever `arr_req`=0, `dout` is 1. This covers the read that completes a restart and any read before the address is complete.
- R8: A read followed by two writes, with the first write carrying 0, forces `idle`=1 unless the read completed a restart.
- R9: A read followed by a write of 1 during address loading forces `idle`=1. A write of 1 in the middle of a byte does the same.
- R10: If any loaded address bit at position `ARR_AW` or higher is 1, the decoder goes idle (`idle`=1, `arr_req`=0) instead of serving data.
- R11: A read pulse and a write pulse in the same clock force `idle`=1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | One-clock pulse per completed bus read cycle |
| wr_stb | input | 1 | One-clock pulse per completed bus write cycle |
| wr_bit | input | 1 | Data-line value carried by a write pulse |
| arr_byte | input | BYTE_W | Byte the array holds at `addr_o` |
| addr_o | output | ARR_AW | Current array address |
| arr_req | output | 1 | Array must present the byte at `addr_o` |
| dout | output | 1 | Bit returned by the next bus read |
| idle | output | 1 | Decoder is in the low-power idle state |

## Verification
The bench builds the decoder with `ARR_AW`=4, so the array has 16 bytes and the 16-bit command address keeps its full width. With only 16 array addresses, every starting address can be loaded, and the wrap from 15 back to 0 happens during sequential reads from several starting points. Because the 12 upper address bits are real, out-of-range addresses such as 0x0010 and 0x8005 can also be driven. The array model computes each byte arithmetically from its address, so every returned bit has a known expected value.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   // one decoded bus event per clock
   typedef enum logic [2:0] {
      EV_NONE,
      EV_RD,
      EV_W0,
      EV_W1,
      EV_BAD
   } bsq_ev_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEEN_R,
      ST_SEEN_RW0,
      ST_LOAD,
      ST_SERVE
   } bsq_st_e;
endpackage

// File: rtl/bsq_evt.sv
module bsq_evt
   import bsq_pkg::*;
(
   input  logic    rd_stb,
   input  logic    wr_stb,
   input  logic    wr_bit,
   output bsq_ev_e ev
);
   always_comb begin
      if (rd_stb && wr_stb)
         ev = EV_BAD;
      else if (rd_stb)
         ev = EV_RD;
      else if (wr_stb)
         ev = wr_bit ? EV_W1 : EV_W0;
      else
         ev = EV_NONE;
   end
endmodule

// File: rtl/bsq_addr.sv
module bsq_addr #(
   parameter int ADDR_W = 16,
   parameter int ARR_AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   input  logic              commit,
   input  logic              inc,
   output logic [ARR_AW-1:0] ptr,
   output logic              full_ok
);
   logic [ADDR_W-2:0] sh_q;
   logic [ADDR_W-1:0] full;

   // the incoming bit completes the word on the final shift
   assign full = {sh_q, shift_bit};

   generate
      if (ARR_AW < ADDR_W) begin : g_hi_chk
         assign full_ok = ~|full[ADDR_W-1:ARR_AW];
      end else begin : g_no_hi
         assign full_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         ptr  <= '0;
      end else begin
         if (shift_en)
            sh_q <= full[ADDR_W-2:0];
         if (commit)
            ptr <= full[ARR_AW-1:0];
         else if (inc)
            ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/bsq_fsm.sv
module bsq_fsm
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   localparam int AC_W = $clog2(ADDR_W),
   localparam int BC_W = $clog2(BYTE_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  bsq_ev_e         ev,
   input  logic            full_ok,
   output bsq_st_e         st,
   output logic [BC_W-1:0] bit_idx,
   output logic            shift_en,
   output logic            shift_bit,
   output logic            commit,
   output logic            inc
);
   localparam logic [AC_W-1:0] ACNT_TOP = AC_W'(ADDR_W - 1);
   localparam logic [BC_W-1:0] BCNT_TOP = BC_W'(BYTE_W - 1);

   bsq_st_e         st_d;
   logic [AC_W-1:0] acnt, acnt_d;
   logic [BC_W-1:0] bit_d;
   logic            rd_seen, rd_seen_d;
   logic            is_wr, a_last, b_last;

   assign is_wr  = (ev == EV_W0) || (ev == EV_W1);
   assign a_last = (acnt == ACNT_TOP);
   assign b_last = (bit_idx == BCNT_TOP);

   assign shift_en  = (st == ST_LOAD) && is_wr;
   assign shift_bit = (ev == EV_W1);
   assign commit    = shift_en && a_last && full_ok;
   assign inc       = (st == ST_SERVE) && (ev == EV_RD) && b_last;

   always_comb begin
      st_d      = st;
      acnt_d    = acnt;
      bit_d     = bit_idx;
      rd_seen_d = rd_seen;
      if (ev == EV_BAD) begin
         st_d = ST_IDLE;
      end else begin
         case (st)
            ST_IDLE: begin
               if (ev == EV_RD) st_d = ST_SEEN_R;
            end
            ST_SEEN_R: begin
               if (ev == EV_W0)      st_d = ST_SEEN_RW0;
               else if (ev == EV_W1) st_d = ST_IDLE;
            end
            ST_SEEN_RW0: begin
               if (ev == EV_RD) begin
                  st_d   = ST_LOAD;
                  acnt_d = '0;
               end else if (is_wr) begin
                  st_d = ST_IDLE;
               end
            end
            ST_LOAD: begin
               if (ev == EV_RD) begin
                  st_d = ST_SEEN_R;
               end else if (is_wr) begin
                  if (!a_last) begin
                     acnt_d = acnt + 1'b1;
                  end else if (full_ok) begin
                     st_d      = ST_SERVE;
                     bit_d     = '0;
                     rd_seen_d = 1'b0;
                  end else begin
                     st_d = ST_IDLE;
                  end
               end
            end
            ST_SERVE: begin
               if (ev == EV_RD) begin
                  rd_seen_d = 1'b1;
                  bit_d     = b_last ? '0 : bit_idx + 1'b1;
               end else if (ev == EV_W0) begin
                  st_d = rd_seen ? ST_SEEN_RW0 : ST_IDLE;
               end else if (ev == EV_W1) begin
                  st_d = ST_IDLE;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         acnt    <= '0;
         bit_idx <= '0;
         rd_seen <= 1'b0;
      end else begin
         st      <= st_d;
         acnt    <= acnt_d;
         bit_idx <= bit_d;
         rd_seen <= rd_seen_d;
      end
   end
endmodule

// File: rtl/bsq_decoder.sv
module bsq_decoder
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int ARR_AW = 11,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic              wr_bit,
   input  logic [BYTE_W-1:0] arr_byte,
   output logic [ARR_AW-1:0] addr_o,
   output logic              arr_req,
   output logic              dout,
   output logic              idle
);
   localparam int BC_W = $clog2(BYTE_W);
   localparam logic [BC_W-1:0] BIT_TOP = BC_W'(BYTE_W - 1);

   generate
      if (ARR_AW < 1 || ARR_AW > ADDR_W) begin : g_bad_aw
         $error("ARR_AW must lie in 1..ADDR_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (BYTE_W < 2 || (1 << BC_W) != BYTE_W) begin : g_bad_byte
         $error("BYTE_W must be a power of two, at least 2");
      end
   endgenerate

   bsq_ev_e         ev;
   bsq_st_e         st;
   logic [BC_W-1:0] bit_idx;
   logic [BC_W-1:0] sel;
   logic            shift_en, shift_bit, commit, inc, full_ok;
   logic            pend_rw0;

   bsq_evt u_evt (
      .rd_stb (rd_stb),
      .wr_stb (wr_stb),
      .wr_bit (wr_bit),
      .ev     (ev)
   );

   bsq_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .full_ok   (full_ok),
      .st        (st),
      .bit_idx   (bit_idx),
      .shift_en  (shift_en),
      .shift_bit (shift_bit),
      .commit    (commit),
      .inc       (inc)
   );

   bsq_addr #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .shift_bit (shift_bit),
      .commit    (commit),
      .inc       (inc),
      .ptr       (addr_o),
      .full_ok   (full_ok)
   );

   // most significant bit of the byte goes out first
   assign sel      = BIT_TOP - bit_idx;
   assign arr_req  = (st == ST_SERVE);
   assign dout     = arr_req ? arr_byte[sel] : 1'b1;
   assign idle     = (st == ST_IDLE);
   assign pend_rw0 = (st == ST_SEEN_RW0);
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
   parameter int ARR_AW = 11,
   parameter int BYTE_W = 8,
   localparam int BC_W = $clog2(BYTE_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic              wr_bit,
   input logic [ARR_AW-1:0] addr_o,
   input logic              arr_req,
   input logic              dout,
   input logic              idle,
   input logic [BC_W-1:0]   bit_idx,
   input logic              pend_rw0
);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

   // R11
   both_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && wr_stb) |=> idle);

   // R6
   wr_one_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && wr_stb && wr_bit) |=> idle);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && rd_stb && !wr_stb && bit_idx == LAST_BIT)
      |=> (addr_o == ARR_AW'($past(addr_o) + 1'b1)));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && !rd_stb) |=> $stable(addr_o));

   // R7
   dout_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arr_req |-> dout);

   // R2
   restart_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_rw0 && rd_stb && !wr_stb) |=> (!idle && !arr_req));

   // R8
   rww_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_rw0 && wr_stb) |=> idle);
endmodule

bind bsq_decoder bsq_chk #(.ARR_AW(ARR_AW), .BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_stb   (rd_stb),
   .wr_stb   (wr_stb),
   .wr_bit   (wr_bit),
   .addr_o   (addr_o),
   .arr_req  (arr_req),
   .dout     (dout),
   .idle     (idle),
   .bit_idx  (bit_idx),
   .pend_rw0 (pend_rw0)
);

// File: tb/sim_bsq_decoder.sv
module sim_bsq_decoder;
   localparam int AW  = 16;
   localparam int RAW = 4;
   localparam int BW  = 8;
   localparam int NA  = 1 << RAW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_stb = 1'b0;
   logic          wr_stb = 1'b0;
   logic          wr_bit = 1'b0;
   logic [BW-1:0] arr_byte;
   logic [RAW-1:0] addr_o;
   logic          arr_req, dout, idle;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   function automatic int byte_of(input int a);
      return (a * 37 + 5) & 255;
   endfunction

   assign arr_byte = BW'(byte_of(int'(addr_o)));

   bsq_decoder #(.ADDR_W(AW), .ARR_AW(RAW), .BYTE_W(BW)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .wr_bit   (wr_bit),
      .arr_byte (arr_byte),
      .addr_o   (addr_o),
      .arr_req  (arr_req),
      .dout     (dout),
      .idle     (idle)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc_rd();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic cyc_wr(input bit b);
      @(negedge clk); wr_stb = 1'b1; wr_bit = b;
      @(negedge clk); wr_stb = 1'b0; wr_bit = 1'b0;
   endtask

   task automatic cyc_both();
      @(negedge clk); rd_stb = 1'b1; wr_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0; wr_stb = 1'b0;
   endtask

   task automatic restart();
      cyc_rd(); cyc_wr(1'b0); cyc_rd();
   endtask

   task automatic load(input logic [AW-1:0] a);
      for (int i = AW - 1; i >= 0; i--) cyc_wr(a[i]);
   endtask

   // reads one byte and checks every bit and the address step
   task automatic read_byte(input int ea);
      for (int k = 0; k < BW; k++) begin
         chk(dout == ((byte_of(ea) >> (BW - 1 - k)) & 1), "R4 data bit", int'(dout),
             (byte_of(ea) >> (BW - 1 - k)) & 1);
         cyc_rd();
      end
      chk(int'(addr_o) == (ea + 1) % NA, "R5 address step", int'(addr_o), (ea + 1) % NA);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog all requirements act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(idle == 1'b1, "R1 idle", int'(idle), 1);
      chk(arr_req == 1'b0, "R1 arr_req", int'(arr_req), 0);
      chk(dout == 1'b1, "R1 dout", int'(dout), 1);

      // sweep every start address, two bytes each, wraps from 15
      for (int a = 0; a < NA; a++) begin
         restart();
         // R2 restart lands in address loading
         chk(!idle && !arr_req, "R2 restart", int'({idle, arr_req}), 0);
         // R7 high while no address
         chk(dout == 1'b1, "R7 dout before address", int'(dout), 1);
         load(AW'(a));
         // R3 address loaded
         chk(arr_req == 1'b1, "R3 arr_req", int'(arr_req), 1);
         chk(int'(addr_o) == a, "R3 addr", int'(addr_o), a);
         read_byte(a);
         read_byte((a + 1) % NA);
         cyc_wr(1'b1);
         // R6 write of 1 after a byte ends the access
         chk(idle == 1'b1, "R6 end read", int'(idle), 1);
         chk(dout == 1'b1, "R7 dout idle", int'(dout), 1);
      end

      // R2 restart aborts a sequential read mid-byte
      restart(); load(16'd3);
      cyc_rd(); cyc_rd(); cyc_rd();
      cyc_wr(1'b0); cyc_rd();
      chk(!idle && !arr_req, "R2 abort read", int'({idle, arr_req}), 0);
      chk(dout == 1'b1, "R7 dout after abort", int'(dout), 1);
      load(16'd9);
      chk(arr_req && int'(addr_o) == 9, "R3 reload", int'(addr_o), 9);
      read_byte(9);

      // R7 and R9: read in address load, then write 1
      restart();
      for (int i = 0; i < 5; i++) cyc_wr(1'b1);
      cyc_rd();
      chk(dout == 1'b1 && !idle, "R7 read mid address", int'({dout, idle}), 2);
      cyc_wr(1'b1);
      chk(idle == 1'b1, "R9 read write1 in address", int'(idle), 1);

      // R9 read then write 1 from idle
      cyc_rd(); cyc_wr(1'b1);
      chk(idle == 1'b1, "R9 read write1", int'(idle), 1);

      // R8 read, write 0, write 0 during address load
      restart(); cyc_wr(1'b0); cyc_rd(); cyc_wr(1'b0); cyc_wr(1'b0);
      chk(idle == 1'b1, "R8 rww w0", int'(idle), 1);
      // R8 read, write 0, write 1 from idle
      cyc_rd(); cyc_wr(1'b0); cyc_wr(1'b1);
      chk(idle == 1'b1, "R8 rww w1", int'(idle), 1);
      chk(arr_req == 1'b0, "R8 no data", int'(arr_req), 0);

      // R9 write 1 in the middle of a byte
      restart(); load(16'd2);
      cyc_rd(); cyc_rd(); cyc_rd();
      cyc_wr(1'b1);
      chk(idle == 1'b1, "R9 mid-byte write1", int'(idle), 1);

      // R10 address above the array
      restart(); load(16'h0010);
      chk(idle && !arr_req, "R10 bit4 set", int'({idle, arr_req}), 2);
      restart(); load(16'h8005);
      chk(idle && !arr_req, "R10 bit15 set", int'({idle, arr_req}), 2);

      // R11 simultaneous read and write
      restart(); load(16'd4);
      cyc_both();
      chk(idle == 1'b1, "R11 both in serve", int'(idle), 1);
      restart(); cyc_both();
      chk(idle == 1'b1, "R11 both in load", int'(idle), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule